// File: doc/BRIEF.md
# Interrupt Source Coalescing State Array

This block keeps a two-bit coalescing state for each of a set of interrupt sources. One bit marks that the source has been forwarded and awaits end-of-interrupt. The other marks that it fired again in the meantime. A trigger from a source reaches the single notify output only when that state allows it, so any source has at most one outstanding notification downstream. Edge sources trigger on a one-cycle pulse. Level sources trigger on a rising level and also keep an extra asserted bit that follows the input.

Software works on the state through a simple load/store port. Each source owns one address page. Offsets inside the management part of the page select the operation: end-of-interrupt, read the state, or force the state. Every management load returns the state as it was before the access. When the page shift selects the split layout, the lower half of each page is a trigger page: a store there fires a software trigger. The management area then starts half a page above. Notifications from several sources are held as pending flags and sent one per cycle, lowest source first.

Top module: `pq_source_array`

## Requirements
- R1: After reset every source state is 00 (idle), every asserted bit is 0, and notify_valid and rsp_valid are low.
- R2: A trigger moves state 00 to 10 and raises a notification. It moves 10 to 11 and leaves 11 and 01 (masked) unchanged, with no notification in those cases.
- R3: A load at management offset 0x000 performs end-of-interrupt and returns the old state. 11 becomes 10 and raises a notification; 10 and 00 become 00; 01 is left unchanged.
- R4: When STORE_EOI_EN is set, a store at management offsets 0x400 to 0x7FF performs end-of-interrupt. Every other store to the management area leaves the state unchanged and produces no response.
- R5: A load at management offset 0x800 (and any other load that is not an end-of-interrupt or a set) returns the state without changing it.
- R6: Loads at management offsets 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 respectively, and return the old state.
- R7: Source s owns the page at s shifted left by PAGE_SHIFT. When PAGE_SHIFT is 13 or 17, address bit PAGE_SHIFT-1 set selects the management half. With that bit clear, a store fires a trigger and a load reads the state. When PAGE_SHIFT is 12 or 16, the whole page is management.
- R8: Load response data is {asserted, P, Q} in bits [2:0]. For a level source, the asserted bit follows the input one cycle later, and a rising level is a trigger. An end-of-interrupt that does not itself retrigger applies a trigger when the asserted bit is set.
- R9: When a port access and a hardware trigger hit the same source in the same cycle, the access is applied first and the trigger acts on the resulting state. The load response still carries the state from before both.
- R10: A load response appears in the cycle after the request. A notification event sets a pending flag, and the lowest pending source is sent on notify_valid/notify_src in the following cycle, one source per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_in | input | NUM_SRC | Per-source trigger: pulse for edge sources, level for level sources |
| req_valid | input | 1 | Port access request |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Byte address: source index above PAGE_SHIFT, offset below |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | 3 | Old {asserted, P, Q} of the addressed source |
| notify_valid | output | 1 | A source notification is presented |
| notify_src | output | SRC_W | Index of the notified source |

## Verification
A load answers in the cycle right after the edge that takes it. A state change is visible to a load issued in the next cycle. A notification shows up one edge after the event that caused it, or later when lower-numbered sources are also waiting. The bench drives its inputs on the falling edge and updates a reference model on the rising edge, in step with the design. On every falling edge it compares both outputs with that model, so each result is checked in exactly the cycle in which it is due. Directed sequences add fixed expected values for the corner cases: the masked state, end-of-interrupt while a level input is still high, and an access colliding with a hardware trigger.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_GET  = 3'd1,
      OP_EOI  = 3'd2,
      OP_SET  = 3'd3,
      OP_TRIG = 3'd4
   } pq_op_e;

   localparam logic [1:0] ST_IDLE   = 2'b00;
   localparam logic [1:0] ST_MASKED = 2'b01;
   localparam logic [1:0] ST_PEND   = 2'b10;
   localparam logic [1:0] ST_QUEUED = 2'b11;

   typedef struct packed {
      logic [1:0] st;
      logic       fire;
   } pq_step_t;

   // trigger: forward only from idle, remember one repeat while pending
   function automatic pq_step_t pq_trigger(input logic [1:0] cur);
      pq_step_t r;
      r.st   = cur;
      r.fire = 1'b0;
      case (cur)
         ST_IDLE: begin r.st = ST_PEND;   r.fire = 1'b1; end
         ST_PEND:       r.st = ST_QUEUED;
         default: ;
      endcase
      return r;
   endfunction

   // end-of-interrupt: queued repeat is forwarded again
   function automatic pq_step_t pq_eoi(input logic [1:0] cur);
      pq_step_t r;
      r.st   = cur;
      r.fire = 1'b0;
      case (cur)
         ST_QUEUED: begin r.st = ST_PEND; r.fire = 1'b1; end
         ST_PEND:         r.st = ST_IDLE;
         default: ;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pq_mmio_decode.sv
module pq_mmio_decode
   import pq_src_pkg::*;
#(
   parameter int NUM_SRC      = 8,
   parameter int PAGE_SHIFT   = 13,
   parameter bit STORE_EOI_EN = 1'b1,
   localparam int SRC_W       = $clog2(NUM_SRC),
   localparam int ADDR_W      = SRC_W + PAGE_SHIFT
)(
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [SRC_W-1:0]  dec_src,
   output pq_op_e            dec_op,
   output logic [1:0]        dec_val
);
   localparam bit SPLIT = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

   logic       mgmt;
   logic [1:0] sel;
   logic       unused_addr;

   assign dec_src     = req_addr[ADDR_W-1:PAGE_SHIFT];
   assign sel         = req_addr[11:10];
   assign dec_val     = req_addr[9:8];
   assign unused_addr = ^req_addr;

   generate
      if (SPLIT) begin : g_split
         assign mgmt = req_addr[PAGE_SHIFT-1];
      end else begin : g_single
         assign mgmt = 1'b1;
      end
   endgenerate

   always_comb begin
      dec_op = OP_NONE;
      if (!mgmt) begin
         dec_op = req_write ? OP_TRIG : OP_GET;
      end else if (!req_write) begin
         case (sel)
            2'b00:   dec_op = OP_EOI;
            2'b11:   dec_op = OP_SET;
            default: dec_op = OP_GET;
         endcase
      end else if (sel == 2'b01 && STORE_EOI_EN) begin
         dec_op = OP_EOI;
      end
   end
endmodule

// File: rtl/pq_cell.sv
module pq_cell
   import pq_src_pkg::*;
#(
   parameter bit IS_LEVEL = 1'b0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  pq_op_e     op,
   input  logic [1:0] set_val,
   input  logic       hw_in,
   output logic [1:0] st,
   output logic       asserted,
   output logic       fire
);
   logic       hw_evt;
   logic [1:0] nxt;
   pq_step_t   step;

   generate
      if (IS_LEVEL) begin : g_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) asserted <= 1'b0;
            else        asserted <= hw_in;
         end
         assign hw_evt = hw_in & ~asserted;
      end else begin : g_edge
         assign asserted = 1'b0;
         assign hw_evt   = hw_in;
      end
   endgenerate

   // port access first, then level retrigger, then hardware trigger
   always_comb begin
      nxt  = st;
      fire = 1'b0;
      step = '0;
      if (hit) begin
         case (op)
            OP_EOI: begin
               step = pq_eoi(st);
               nxt  = step.st;
               fire = step.fire;
               if (asserted && !step.fire) begin
                  step = pq_trigger(nxt);
                  nxt  = step.st;
                  fire = step.fire;
               end
            end
            OP_SET:  nxt = set_val;
            OP_TRIG: begin
               step = pq_trigger(st);
               nxt  = step.st;
               fire = step.fire;
            end
            default: ;
         endcase
      end
      if (hw_evt) begin
         step = pq_trigger(nxt);
         nxt  = step.st;
         fire = fire | step.fire;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   assert_notify_sets_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> st[1]);
   assert_masked_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MASKED && !hit) |=> st == ST_MASKED);
   assert_p_needs_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st[1] && !hit) |=> st[1]);
   assert_idle_trigger_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !hit && hw_evt) |-> fire);
endmodule

// File: rtl/pq_notify_arb.sv
module pq_notify_arb #(
   parameter int NUM_SRC = 8,
   localparam int SRC_W  = $clog2(NUM_SRC)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] fire_vec,
   output logic               notify_valid,
   output logic [SRC_W-1:0]   notify_src
);
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] grant;
   logic [SRC_W-1:0]   pick;
   logic               any;

   always_comb begin
      pick = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) pick = SRC_W'(i);
      end
      any   = |pend;
      grant = any ? (NUM_SRC'(1) << pick) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend         <= '0;
         notify_valid <= 1'b0;
         notify_src   <= '0;
      end else begin
         pend         <= (pend & ~grant) | fire_vec;
         notify_valid <= any;
         notify_src   <= pick;
      end
   end

   assert_quiet_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> !notify_valid);
   assert_event_reaches_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_vec != '0) |=> ##1 notify_valid);
endmodule

// File: rtl/pq_source_array.sv
module pq_source_array
   import pq_src_pkg::*;
#(
   parameter int NUM_SRC      = 8,
   parameter int PAGE_SHIFT   = 13,
   parameter bit STORE_EOI_EN = 1'b1,
   parameter int LEVEL_FIRST  = 6,
   localparam int SRC_W       = $clog2(NUM_SRC),
   localparam int ADDR_W      = SRC_W + PAGE_SHIFT
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] hw_in,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               rsp_valid,
   output logic [2:0]         rsp_data,
   output logic               notify_valid,
   output logic [SRC_W-1:0]   notify_src
);
   generate
      if (NUM_SRC < 2 || (1 << SRC_W) != NUM_SRC) begin : g_bad_count
         $error("NUM_SRC must be a power of two, at least 2");
      end
      if (!(PAGE_SHIFT == 12 || PAGE_SHIFT == 13 || PAGE_SHIFT == 16 || PAGE_SHIFT == 17)) begin : g_bad_shift
         $error("PAGE_SHIFT must be 12, 13, 16 or 17");
      end
      if (LEVEL_FIRST < 0 || LEVEL_FIRST > NUM_SRC) begin : g_bad_level
         $error("LEVEL_FIRST out of range");
      end
   endgenerate

   logic [SRC_W-1:0]        dec_src;
   pq_op_e                  dec_op;
   logic [1:0]              dec_val;
   logic [NUM_SRC-1:0][1:0] st_vec;
   logic [NUM_SRC-1:0]      asr_vec;
   logic [NUM_SRC-1:0]      fire_vec;

   pq_mmio_decode #(
      .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT), .STORE_EOI_EN(STORE_EOI_EN)
   ) u_decode (
      .req_write(req_write), .req_addr(req_addr),
      .dec_src(dec_src), .dec_op(dec_op), .dec_val(dec_val)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic hit;
      assign hit = req_valid && (dec_src == SRC_W'(g)) && (dec_op != OP_NONE);
      pq_cell #(.IS_LEVEL(g >= LEVEL_FIRST)) u_cell (
         .clk(clk), .rst_n(rst_n), .hit(hit), .op(dec_op), .set_val(dec_val),
         .hw_in(hw_in[g]), .st(st_vec[g]), .asserted(asr_vec[g]), .fire(fire_vec[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         rsp_data  <= {asr_vec[dec_src], st_vec[dec_src]};
      end
   end

   pq_notify_arb #(.NUM_SRC(NUM_SRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .fire_vec(fire_vec),
      .notify_valid(notify_valid), .notify_src(notify_src)
   );

   assert_load_answers_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);
   assert_store_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: tb/pq_source_array_bench.sv
`timescale 1ns/1ps
module pq_source_array_bench;
   localparam int N     = 8;
   localparam int SHIFT = 13;
   localparam int LVL   = 6;
   localparam int SW    = 3;
   localparam int AW    = SW + SHIFT;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  hw_in = '0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic [2:0]    rsp_data;
   logic          notify_valid;
   logic [SW-1:0] notify_src;

   int    n_checks = 0;
   int    n_fail = 0;
   string tag = "R1";
   bit    done = 1'b0;

   always #2 clk = ~clk;

   pq_source_array #(.NUM_SRC(N), .PAGE_SHIFT(SHIFT), .STORE_EOI_EN(1'b1),
                     .LEVEL_FIRST(LVL)) u_pq_source_array (
      .clk(clk), .rst_n(rst_n), .hw_in(hw_in), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .notify_valid(notify_valid), .notify_src(notify_src)
   );

   // ---------------- reference model ----------------
   logic [1:0] m_st [N];
   logic       m_asr [N];
   logic [N-1:0] m_pend;
   logic       m_nv, m_rv;
   logic [SW-1:0] m_ns;
   logic [2:0] m_rd;

   function automatic logic [2:0] f_trig(input logic [1:0] s); // {st, fire}
      if (s == 2'b00) return 3'b101;
      if (s == 2'b10) return 3'b110;
      return {s, 1'b0};
   endfunction
   function automatic logic [2:0] f_eoi(input logic [1:0] s);
      if (s == 2'b11) return 3'b101;
      if (s == 2'b10) return 3'b000;
      return {s, 1'b0};
   endfunction
   // 0 none, 1 get, 2 eoi, 3 set, 4 trigger
   function automatic int f_op(input logic wr, input logic [AW-1:0] a);
      if (!a[SHIFT-1]) return wr ? 4 : 1;
      if (!wr) begin
         if (a[11:10] == 2'b00) return 2;
         if (a[11:10] == 2'b11) return 3;
         return 1;
      end
      if (a[11:10] == 2'b01) return 2;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_st[i] = 2'b00; m_asr[i] = 1'b0; end
         m_pend = '0; m_nv = 0; m_ns = '0; m_rv = 0; m_rd = '0;
      end else begin
         int op, s;
         logic [N-1:0] newp;
         logic [2:0] r;
         logic f, evt;
         op = f_op(req_write, req_addr);
         s  = int'(req_addr[AW-1:SHIFT]);
         m_rv = req_valid && !req_write;
         m_rd = {m_asr[s], m_st[s]};
         m_nv = |m_pend;
         m_ns = '0;
         for (int i = N - 1; i >= 0; i--) if (m_pend[i]) m_ns = SW'(i);
         if (m_nv) m_pend[m_ns] = 1'b0;
         newp = '0;
         for (int i = 0; i < N; i++) begin
            f = 0;
            if (req_valid && s == i) begin
               if (op == 2) begin
                  r = f_eoi(m_st[i]); m_st[i] = r[2:1]; f = r[0];
                  if (m_asr[i] && !f) begin r = f_trig(m_st[i]); m_st[i] = r[2:1]; f = r[0]; end
               end else if (op == 3) m_st[i] = req_addr[9:8];
               else if (op == 4) begin r = f_trig(m_st[i]); m_st[i] = r[2:1]; f = r[0]; end
            end
            evt = (i >= LVL) ? (hw_in[i] && !m_asr[i]) : hw_in[i];
            if (evt) begin r = f_trig(m_st[i]); m_st[i] = r[2:1]; f = f | r[0]; end
            newp[i] = f;
            m_asr[i] = (i >= LVL) ? hw_in[i] : 1'b0;
         end
         m_pend = m_pend | newp;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cycle();
      @(negedge clk);
      if (rst_n && !done) begin
         check({tag, " notify_valid"}, int'(notify_valid), int'(m_nv));
         if (m_nv) check({tag, " notify_src R10"}, int'(notify_src), int'(m_ns));
         check({tag, " rsp_valid R10"}, int'(rsp_valid), int'(m_rv));
         if (m_rv) check({tag, " rsp_data"}, int'(rsp_data), int'(m_rd));
      end
   endtask

   function automatic logic [AW-1:0] adr(input int s, input bit mg, input int off);
      return AW'((s << SHIFT) | (int'(mg) << (SHIFT - 1)) | off);
   endfunction

   task automatic access(input int s, input bit mg, input int off, input bit wr,
                         output logic [2:0] data);
      req_valid = 1'b1; req_write = wr; req_addr = adr(s, mg, off);
      cycle();
      data = rsp_data;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic pulse(input logic [N-1:0] m);
      hw_in = hw_in | m;
      cycle();
      hw_in = hw_in & ~(m & {{(N-LVL){1'b0}}, {LVL{1'b1}}});
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) cycle();
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
      $finish;
   end

   initial begin
      logic [2:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      tag = "R1";
      cycle();
      check("R1 notify_valid", int'(notify_valid), 0);
      check("R1 rsp_valid", int'(rsp_valid), 0);
      access(0, 1, 'h800, 0, d); check("R1 state src0", int'(d), 0);
      access(7, 1, 'h800, 0, d); check("R1 state src7", int'(d), 0);
      // R2 trigger coalescing
      tag = "R2";
      pulse(8'h02); idle(1);
      access(1, 1, 'h800, 0, d); check("R2 first trigger", int'(d), 2);
      pulse(8'h02); pulse(8'h02);
      access(1, 1, 'h800, 0, d); check("R2 queued", int'(d), 3);
      // R3 EOI load
      tag = "R3";
      access(1, 1, 'h000, 0, d); check("R3 eoi old queued", int'(d), 3);
      access(1, 1, 'h000, 0, d); check("R3 eoi old pending", int'(d), 2);
      access(1, 1, 'h800, 0, d); check("R3 after eoi", int'(d), 0);
      // R6 set, R2 masked
      tag = "R6";
      access(2, 1, 'hD00, 0, d); check("R6 set01 old", int'(d), 0);
      pulse(8'h04); idle(2);
      access(2, 1, 'h800, 0, d); check("R2 masked stays", int'(d), 1);
      access(2, 1, 'hF00, 0, d); check("R6 set11 old", int'(d), 1);
      access(2, 1, 'hC00, 0, d); check("R6 set00 old", int'(d), 3);
      // R4 store EOI and ignored store
      tag = "R4";
      pulse(8'h02); idle(1);
      access(1, 1, 'h400, 1, d);
      access(1, 1, 'h800, 0, d); check("R4 store eoi", int'(d), 0);
      pulse(8'h02);
      access(1, 1, 'h800, 1, d);
      access(1, 1, 'hE00, 1, d);
      access(1, 1, 'h800, 0, d); check("R4 store ignored", int'(d), 2);
      access(1, 1, 'h000, 0, d);
      // R5 get does not change state
      tag = "R5";
      access(1, 1, 'h900, 0, d); access(1, 1, 'h800, 0, d);
      check("R5 get no change", int'(d), 0);
      // R7 trigger page
      tag = "R7";
      access(3, 0, 'h10, 1, d); idle(1);
      access(3, 1, 'h800, 0, d); check("R7 trigger page store", int'(d), 2);
      access(3, 0, 'h00, 0, d); check("R7 trigger page load", int'(d), 2);
      access(3, 1, 'h000, 0, d);
      // R8 level source
      tag = "R8";
      hw_in[6] = 1'b1; cycle(); idle(1);
      access(6, 1, 'h800, 0, d); check("R8 asserted pending", int'(d), 6);
      access(6, 1, 'h000, 0, d); check("R8 eoi while asserted", int'(d), 6);
      access(6, 1, 'h800, 0, d); check("R8 retriggered", int'(d), 6);
      hw_in[6] = 1'b0; cycle();
      access(6, 1, 'h000, 0, d); check("R8 eoi deasserted", int'(d), 2);
      access(6, 1, 'h800, 0, d); check("R8 idle", int'(d), 0);
      // R9 same-cycle access and trigger
      tag = "R9";
      pulse(8'h10); idle(2);
      hw_in[4] = 1'b1;
      access(4, 1, 'h000, 0, d); hw_in[4] = 1'b0;
      check("R9 old value", int'(d), 2);
      access(4, 1, 'h800, 0, d); check("R9 trigger after eoi", int'(d), 2);
      access(4, 1, 'h000, 0, d);
      // R10 ordering
      tag = "R10";
      idle(3);
      pulse(8'h21); cycle();
      check("R10 first src", int'(notify_valid) * 16 + int'(notify_src), 16);
      cycle();
      check("R10 second src", int'(notify_valid) * 16 + int'(notify_src), 21);
      access(0, 1, 'h000, 0, d); access(5, 1, 'h000, 0, d);
      // random phase
      tag = "RND R2 R3 R6 R8";
      begin
         int seed_dummy;
         seed_dummy = $urandom(32'h5eed1234);
      end
      for (int c = 0; c < 4000; c++) begin
         int offs[8] = '{'h000, 'h400, 'h800, 'hC00, 'hD00, 'hE00, 'hF00, 'h200};
         logic [N-1:0] h;
         h = hw_in;
         for (int i = 0; i < N; i++) begin
            if (i < LVL) h[i] = ($urandom % 8) == 0;
            else if (($urandom % 16) == 0) h[i] = ~h[i];
         end
         hw_in = h;
         req_valid = ($urandom % 2) == 1;
         req_write = ($urandom % 3) == 0;
         req_addr  = adr(int'($urandom % N), ($urandom % 4) != 0, offs[$urandom % 8]);
         cycle();
      end
      req_valid = 1'b0; hw_in = '0;
      idle(12);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule